// File: doc/BRIEF.md
# I2C Master Byte Engine

This block is the bus-facing half of an I2C master. A host sequencer hands it one operation at a time: a START (which becomes a repeated START when the engine already owns the bus), a STOP, a byte write, or a byte read with a chosen acknowledge. The engine produces the open-drain waveforms on SCL and SDA, samples the wired-AND lines back, and reports the result of the operation as an 8-bit status code together with a busy/done handshake.

The bit rate is set by a divider value and a two-bit prescaler select. Every bit is built from four quarter phases, so SDA is always moved in the middle of the SCL low time and sampled in the middle of the SCL high time. A target that holds SCL low while the engine has released it simply pauses the phase timer.

A full write is START, address byte, data bytes, STOP. A register read is START, address with write direction, command byte, repeated START, address with read direction, reads with ACK, a final read with NACK, then STOP.

Top module: `i2cm_engine`

## Requirements
- R1: Within a byte operation, consecutive SCL rising edges are 16 + 2 × div × P system clocks apart, where P is 1, 4, 16 or 64 for psel = 0, 1, 2, 3.
- R2: A command (cmd_op 1 = START, 2 = STOP, 3 = WRITE, 4 = READ) accepted while busy is low raises busy and lowers done on the next clock; done rises again in the cycle busy falls.
- R3: A START on a released bus makes SDA fall while SCL is high and reports status 0x10; a START while the engine holds the bus first releases SDA with SCL low, then pulls SDA low with SCL high, and reports 0x18.
- R4: A STOP makes SDA rise while SCL is high and leaves both scl_oe and sda_oe low; it reports 0xF8.
- R5: During a byte operation SDA changes only while SCL is low; no START or STOP appears on the bus.
- R6: A write sends cmd_wdata most significant bit first and samples the acknowledge in the ninth clock. The first write after a START reports 0x20/0x28 (ACK/NACK) when wdata bit 0 is 0 and 0x40/0x48 when it is 1; later writes report 0x30/0x38.
- R7: A read shifts eight bits in most significant bit first onto rdata; in the ninth clock the engine pulls SDA low when cmd_ack_en was set and releases it otherwise, reporting 0x50 or 0x58 respectively.
- R8: The three low bits of status are always zero.
- R9: After reset scl_oe and sda_oe are low, busy is low, done is high and status is 0xF8.
- R10: A STOP issued while the engine does not hold the bus produces no line activity, leaves busy low and done high, and sets status 0xF8.
- R11: A command presented while busy is high is ignored; the running operation finishes with its own result.
- R12: While the engine has released SCL but the line reads low, the quarter-phase timer holds, lengthening that high phase by the hold time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, accepted when busy is low |
| cmd_op | input | 3 | Operation: 1 START, 2 STOP, 3 WRITE, 4 READ |
| cmd_wdata | input | 8 | Byte to send on WRITE |
| cmd_ack_en | input | 1 | On READ: 1 sends ACK, 0 sends NACK |
| div | input | DIV_W | Bit-rate divider |
| psel | input | 2 | Prescaler select (1, 4, 16, 64) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Last operation complete |
| status | output | 8 | Result code of the last operation |
| rdata | output | 8 | Byte shifted in by the last byte operation |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| scl_in | input | 1 | Sampled SCL line |
| sda_in | input | 1 | Sampled SDA line |

## Verification
The assertions assume scl_in and sda_in are already synchronous to clk and that the line reflects scl_oe in the same cycle, so a released SCL reads high unless a target holds it. They also assume div and psel stay constant while busy is high. The bench models the bus as a combinational wired-AND of the engine and a behavioural target, changes target drive only on SCL edges or between clock edges, and alters div and psel only between operations.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_START = 3'd1,
    OP_STOP  = 3'd2,
    OP_WRITE = 3'd3,
    OP_READ  = 3'd4
  } op_e;

  localparam logic [7:0] SC_IDLE    = 8'hF8;
  localparam logic [7:0] SC_START   = 8'h10;
  localparam logic [7:0] SC_RSTART  = 8'h18;
  localparam logic [7:0] SC_AW_ACK  = 8'h20;
  localparam logic [7:0] SC_AW_NACK = 8'h28;
  localparam logic [7:0] SC_DW_ACK  = 8'h30;
  localparam logic [7:0] SC_DW_NACK = 8'h38;
  localparam logic [7:0] SC_AR_ACK  = 8'h40;
  localparam logic [7:0] SC_AR_NACK = 8'h48;
  localparam logic [7:0] SC_RD_ACK  = 8'h50;
  localparam logic [7:0] SC_RD_NACK = 8'h58;
endpackage

// File: rtl/i2cm_qtimer.sv
module i2cm_qtimer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  input  logic [1:0]       psel,
  input  logic             scl_in,
  output logic [1:0]       phase,
  output logic             qtick
);
  localparam int HW = DIV_W + 8;

  logic [HW-1:0] half, len_lo, len_hi, cnt_q, cnt_d;
  logic [1:0]    ph_q, ph_d;
  logic          hold;

  always_comb begin
    half   = HW'(8) + (HW'(div) << {psel, 1'b0});
    len_hi = half >> 1;
    len_lo = half - len_hi;
    hold   = ph_q[1] & ~scl_in;
    qtick  = run & ~hold & (cnt_q == HW'(1));
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    if (!run) begin
      ph_d  = 2'd0;
      cnt_d = len_lo;
    end else if (!hold) begin
      if (cnt_q == HW'(1)) begin
        ph_d  = ph_q + 2'd1;
        cnt_d = ph_d[0] ? len_hi : len_lo;
      end else begin
        cnt_d = cnt_q - HW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= 2'd0;
      cnt_q <= HW'(8);
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign phase = ph_q;

  assert_cnt_nonzero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q != '0));
  assert_phase_advance_R1: assert property (@(posedge clk) disable iff (!rst_n)
    qtick |=> (ph_q == 2'($past(ph_q) + 2'd1)));
  assert_stretch_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (run && ph_q[1] && !scl_in) |=> $stable(ph_q));
endmodule

// File: rtl/i2cm_seq.sv
module i2cm_seq
  import i2cm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_op,
  input  logic [7:0] cmd_wdata,
  input  logic       cmd_ack_en,
  input  logic       sda_in,
  input  logic [1:0] phase,
  input  logic       qtick,
  output logic       busy,
  output logic       done,
  output logic [7:0] status,
  output logic [7:0] rdata,
  output logic       scl_oe,
  output logic       sda_oe
);
  op_e        op_q, op_d;
  logic [7:0] sh_q, sh_d, stat_q, stat_d;
  logic [3:0] slot_q, slot_d;
  logic       busy_q, busy_d, done_q, done_d, sda_q, sda_d;
  logic       held_q, held_d, addr_q, addr_d, dir_q, dir_d;
  logic       acken_q, acken_d, nack_q, nack_d;
  logic       accept, stop_free, launch, byte_op, last_slot, upd;

  always_comb begin
    accept    = cmd_valid & ~busy_q;
    stop_free = (cmd_op == 3'd2) & ~held_q;
    launch    = accept & ~stop_free & (cmd_op >= 3'd1) & (cmd_op <= 3'd4);
    byte_op   = (op_q == OP_WRITE) || (op_q == OP_READ);
    last_slot = (slot_q == 4'd8);
    upd       = launch | (accept & stop_free) | (busy_q & qtick);

    busy_d = busy_q;  done_d = done_q;  op_d = op_q;    sh_d = sh_q;
    slot_d = slot_q;  sda_d = sda_q;    held_d = held_q; addr_d = addr_q;
    dir_d = dir_q;    acken_d = acken_q; nack_d = nack_q; stat_d = stat_q;

    if (accept && stop_free) begin
      stat_d = SC_IDLE;
    end else if (launch) begin
      busy_d  = 1'b1;
      done_d  = 1'b0;
      op_d    = op_e'(cmd_op);
      sh_d    = cmd_wdata;
      slot_d  = 4'd0;
      acken_d = cmd_ack_en;
      dir_d   = cmd_wdata[0];
      if (cmd_op == 3'd1) sda_d = 1'b0;
    end else if (busy_q && qtick) begin
      unique case (phase)
        2'd0: begin
          if (op_q == OP_STOP)       sda_d = 1'b1;
          else if (op_q == OP_WRITE) sda_d = last_slot ? 1'b0 : ~sh_q[7];
          else if (op_q == OP_READ)  sda_d = last_slot ? acken_q : 1'b0;
        end
        2'd1: ;
        2'd2: begin
          if (op_q == OP_START)     sda_d = 1'b1;
          else if (op_q == OP_STOP) sda_d = 1'b0;
          else if (byte_op) begin
            if (last_slot) nack_d = sda_in;
            else           sh_d   = {sh_q[6:0], sda_in};
          end
        end
        2'd3: begin
          if (byte_op && !last_slot) begin
            slot_d = slot_q + 4'd1;
          end else begin
            busy_d = 1'b0;
            done_d = 1'b1;
            unique case (op_q)
              OP_START: begin
                stat_d = held_q ? SC_RSTART : SC_START;
                held_d = 1'b1;
                addr_d = 1'b1;
              end
              OP_STOP: begin
                stat_d = SC_IDLE;
                held_d = 1'b0;
                addr_d = 1'b0;
              end
              OP_WRITE: begin
                if (addr_q) stat_d = dir_q ? (nack_q ? SC_AR_NACK : SC_AR_ACK)
                                           : (nack_q ? SC_AW_NACK : SC_AW_ACK);
                else        stat_d = nack_q ? SC_DW_NACK : SC_DW_ACK;
                addr_d = 1'b0;
              end
              OP_READ: stat_d = acken_q ? SC_RD_ACK : SC_RD_NACK;
              default: ;
            endcase
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;  done_q <= 1'b1;  op_q <= OP_NONE;  sh_q <= 8'h00;
      slot_q <= 4'd0;  sda_q <= 1'b0;   held_q <= 1'b0;   addr_q <= 1'b0;
      dir_q <= 1'b0;   acken_q <= 1'b0; nack_q <= 1'b0;   stat_q <= SC_IDLE;
    end else if (upd) begin
      busy_q <= busy_d;  done_q <= done_d;   op_q <= op_d;     sh_q <= sh_d;
      slot_q <= slot_d;  sda_q <= sda_d;     held_q <= held_d; addr_q <= addr_d;
      dir_q <= dir_d;    acken_q <= acken_d; nack_q <= nack_d; stat_q <= stat_d;
    end
  end

  always_comb begin
    if (!busy_q)               scl_oe = held_q;
    else if (op_q == OP_START) scl_oe = held_q & (phase == 2'd0);
    else                       scl_oe = ~phase[1];
  end

  assign sda_oe = sda_q;
  assign busy   = busy_q;
  assign done   = done_q;
  assign status = stat_q;
  assign rdata  = sh_q;

  assert_status_low_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    status[2:0] == 3'b000);
  assert_done_busy_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_q && done_q));
  assert_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy_q && ((cmd_op == 3'd1) || (cmd_op == 3'd3) || (cmd_op == 3'd4)))
      |=> (busy_q && !done_q));
  assert_ignore_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cmd_valid) |=> $stable(op_q));
  assert_sda_steady_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && byte_op && phase[1] && $past(phase[1])) |-> $stable(sda_q));
  assert_stop_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_q) && (op_q == OP_STOP)) |-> (!scl_oe && !sda_oe));
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [7:0]       cmd_wdata,
  input  logic             cmd_ack_en,
  input  logic [DIV_W-1:0] div,
  input  logic [1:0]       psel,
  output logic             busy,
  output logic             done,
  output logic [7:0]       status,
  output logic [7:0]       rdata,
  output logic             scl_oe,
  output logic             sda_oe,
  input  logic             scl_in,
  input  logic             sda_in
);
  logic [1:0] rst_sync;
  logic       rst_ni;
  logic [1:0] phase;
  logic       qtick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  i2cm_qtimer #(.DIV_W(DIV_W)) u_qtimer (
    .clk    (clk),
    .rst_n  (rst_ni),
    .run    (busy),
    .div    (div),
    .psel   (psel),
    .scl_in (scl_in),
    .phase  (phase),
    .qtick  (qtick)
  );

  i2cm_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_ni),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_wdata  (cmd_wdata),
    .cmd_ack_en (cmd_ack_en),
    .sda_in     (sda_in),
    .phase      (phase),
    .qtick      (qtick),
    .busy       (busy),
    .done       (done),
    .status     (status),
    .rdata      (rdata),
    .scl_oe     (scl_oe),
    .sda_oe     (sda_oe)
  );
endmodule

// File: tb/i2cm_engine_tb.sv
module i2cm_engine_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [7:0] cmd_wdata = 8'h00;
  logic       cmd_ack_en = 1'b0;
  logic [7:0] div = 8'd2;
  logic [1:0] psel = 2'd0;
  logic       busy, done, scl_oe, sda_oe;
  logic [7:0] status, rdata;

  int         slv_mode = 0;
  logic       slv_ack = 1'b0;
  logic [7:0] slv_byte = 8'h00;
  logic       slv_scl = 1'b0;
  logic       slv_sda;
  wire        scl_line = ~(scl_oe | slv_scl);
  wire        sda_line = ~(sda_oe | slv_sda);

  int bcnt = -1, n_start = 0, n_stop = 0, n_sclfall = 0;
  logic [7:0] rx = 8'h00;
  logic       m_ack = 1'b0;
  int cyc = 0, ridx = 0;
  int rise_cyc [16];
  logic scl_d = 1'b1;
  logic stretch_en = 1'b0;
  int n_pass = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  i2cm_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_wdata(cmd_wdata), .cmd_ack_en(cmd_ack_en), .div(div), .psel(psel),
    .busy(busy), .done(done), .status(status), .rdata(rdata),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .scl_in(scl_line), .sda_in(sda_line)
  );

  function automatic logic slave_pull(int m, int b, logic a, logic [7:0] d);
    if (m == 1) return (b == 8) && a;
    if (m == 2 && b >= 0 && b < 8) return !d[7-b];
    return 1'b0;
  endfunction
  assign slv_sda = slave_pull(slv_mode, bcnt, slv_ack, slv_byte);

  always @(negedge sda_line) if (scl_line === 1'b1) begin bcnt = -1; n_start++; end
  always @(posedge sda_line) if (scl_line === 1'b1) n_stop++;
  always @(posedge scl_line) begin
    if (bcnt >= 0 && bcnt < 8) rx = {rx[6:0], sda_line};
    else if (bcnt == 8) m_ack = !sda_line;
  end
  always @(negedge scl_line) begin
    n_sclfall++;
    bcnt = (bcnt >= 8) ? 0 : bcnt + 1;
  end
  always @(negedge clk) begin
    cyc++;
    if (scl_line && !scl_d) begin
      if (ridx < 16) rise_cyc[ridx] = cyc;
      ridx++;
    end
    scl_d = scl_line;
  end
  always @(negedge scl_line) if (stretch_en && ridx == 2) begin
    slv_scl = 1'b1;
    @(negedge scl_oe);
    repeat (30) @(posedge clk);
    #2 slv_scl = 1'b0;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    if (ok) n_pass++;
    else begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [7:0] wd, input logic ae);
    @(negedge clk);
    cmd_op = op; cmd_wdata = wd; cmd_ack_en = ae; cmd_valid = 1'b1; ridx = 0;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy && !done, "R2", "busy/done after issue", {busy, done}, 2'b10);
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    chk(done, req, "completion", done, 1);
  endtask

  task automatic do_cmd(input logic [2:0] op, input logic [7:0] wd, input logic ae,
                        input string req);
    issue(op, wd, ae);
    wait_done(req);
  endtask

  task automatic t_reset;
    chk(!scl_oe && !sda_oe, "R9", "lines after reset", {scl_oe, sda_oe}, 0);
    chk(!busy && done, "R9", "busy/done after reset", {busy, done}, 2'b01);
    chk(status == 8'hF8, "R9", "status after reset", status, 8'hF8);
  endtask

  task automatic t_write;
    int s0, p0;
    div = 8'd2; psel = 2'd0; slv_mode = 1;
    s0 = n_start;
    do_cmd(3'd1, 8'h00, 1'b0, "R3");
    chk(status == 8'h10, "R3", "START status", status, 8'h10);
    chk(n_start == s0 + 1, "R3", "START on bus", n_start - s0, 1);
    s0 = n_start; p0 = n_stop; slv_ack = 1'b1;
    do_cmd(3'd3, 8'hA4, 1'b0, "R6");
    chk(status == 8'h20, "R6", "SLA+W ack status", status, 8'h20);
    chk(rx == 8'hA4, "R6", "address bits on bus", rx, 8'hA4);
    chk(rise_cyc[2] - rise_cyc[1] == 20, "R1", "SCL period div2 psel0",
        rise_cyc[2] - rise_cyc[1], 20);
    do_cmd(3'd3, 8'h3C, 1'b0, "R6");
    chk(status == 8'h30, "R6", "data ack status", status, 8'h30);
    chk(rx == 8'h3C, "R6", "data bits on bus", rx, 8'h3C);
    slv_ack = 1'b0;
    do_cmd(3'd3, 8'h81, 1'b0, "R6");
    chk(status == 8'h38, "R6", "data nack status", status, 8'h38);
    chk(rx == 8'h81, "R6", "data bits on bus", rx, 8'h81);
    chk(n_start == s0 && n_stop == p0, "R5", "no START/STOP inside bytes",
        (n_start - s0) + (n_stop - p0), 0);
    p0 = n_stop;
    do_cmd(3'd2, 8'h00, 1'b0, "R4");
    chk(n_stop == p0 + 1, "R4", "STOP on bus", n_stop - p0, 1);
    chk(!scl_oe && !sda_oe, "R4", "lines released", {scl_oe, sda_oe}, 0);
    chk(status == 8'hF8, "R4", "STOP status", status, 8'hF8);
    slv_mode = 0;
  endtask

  task automatic t_read;
    int s0;
    div = 8'd3; psel = 2'd1; slv_mode = 1; slv_ack = 1'b1;
    do_cmd(3'd1, 8'h00, 1'b0, "R3");
    do_cmd(3'd3, 8'hA4, 1'b0, "R6");
    chk(status == 8'h20, "R6", "SLA+W ack status", status, 8'h20);
    s0 = n_start;
    do_cmd(3'd1, 8'h00, 1'b0, "R3");
    chk(status == 8'h18, "R3", "repeated START status", status, 8'h18);
    chk(n_start == s0 + 1, "R3", "repeated START on bus", n_start - s0, 1);
    do_cmd(3'd3, 8'hA5, 1'b0, "R6");
    chk(status == 8'h40, "R6", "SLA+R ack status", status, 8'h40);
    slv_mode = 2; slv_byte = 8'hC6;
    do_cmd(3'd4, 8'h00, 1'b1, "R7");
    chk(rdata == 8'hC6, "R7", "read byte with ACK", rdata, 8'hC6);
    chk(m_ack == 1'b1, "R7", "ACK driven", m_ack, 1);
    chk(status == 8'h50, "R7", "read ACK status", status, 8'h50);
    chk(rise_cyc[2] - rise_cyc[1] == 40, "R1", "SCL period div3 psel1",
        rise_cyc[2] - rise_cyc[1], 40);
    slv_byte = 8'h39;
    do_cmd(3'd4, 8'h00, 1'b0, "R7");
    chk(rdata == 8'h39, "R7", "read byte with NACK", rdata, 8'h39);
    chk(m_ack == 1'b0, "R7", "NACK driven", m_ack, 0);
    chk(status == 8'h58, "R7", "read NACK status", status, 8'h58);
    slv_mode = 0;
    do_cmd(3'd2, 8'h00, 1'b0, "R4");
  endtask

  task automatic t_addr_nack;
    div = 8'd2; psel = 2'd0; slv_mode = 1; slv_ack = 1'b0;
    do_cmd(3'd1, 8'h00, 1'b0, "R3");
    do_cmd(3'd3, 8'hB0, 1'b0, "R6");
    chk(status == 8'h28, "R6", "SLA+W nack status", status, 8'h28);
    do_cmd(3'd1, 8'h00, 1'b0, "R3");
    do_cmd(3'd3, 8'hB1, 1'b0, "R6");
    chk(status == 8'h48, "R6", "SLA+R nack status", status, 8'h48);
    do_cmd(3'd2, 8'h00, 1'b0, "R4");
    slv_mode = 0;
  endtask

  task automatic t_free_stop;
    int f0, s0, p0;
    bit saw_busy = 0;
    f0 = n_sclfall; s0 = n_start; p0 = n_stop;
    @(negedge clk);
    cmd_op = 3'd2; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(!busy && done, "R10", "busy/done after idle STOP", {busy, done}, 2'b01);
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (busy) saw_busy = 1;
    end
    chk(!saw_busy, "R10", "no operation started", saw_busy, 0);
    chk(n_sclfall == f0 && n_start == s0 && n_stop == p0, "R10", "no line activity",
        (n_sclfall - f0) + (n_start - s0) + (n_stop - p0), 0);
    chk(status == 8'hF8, "R10", "status", status, 8'hF8);
  endtask

  task automatic t_busy_ignore;
    int s0, p0;
    div = 8'd2; psel = 2'd0; slv_mode = 1; slv_ack = 1'b1;
    do_cmd(3'd1, 8'h00, 1'b0, "R3");
    s0 = n_start; p0 = n_stop;
    issue(3'd3, 8'h54, 1'b0);
    repeat (60) @(negedge clk);
    cmd_op = 3'd1; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_done("R11");
    chk(status == 8'h20, "R11", "status of running write", status, 8'h20);
    chk(rx == 8'h54, "R11", "byte completed", rx, 8'h54);
    chk(n_start == s0 && n_stop == p0, "R11", "no extra condition",
        (n_start - s0) + (n_stop - p0), 0);
    do_cmd(3'd2, 8'h00, 1'b0, "R4");
    slv_mode = 0;
  endtask

  task automatic t_stretch;
    div = 8'd2; psel = 2'd0; slv_mode = 1; slv_ack = 1'b1;
    do_cmd(3'd1, 8'h00, 1'b0, "R3");
    stretch_en = 1'b1;
    do_cmd(3'd3, 8'h96, 1'b0, "R12");
    stretch_en = 1'b0;
    chk(rise_cyc[2] - rise_cyc[1] == 50, "R12", "stretched bit spacing",
        rise_cyc[2] - rise_cyc[1], 50);
    chk(rise_cyc[3] - rise_cyc[2] == 20, "R12", "spacing after stretch",
        rise_cyc[3] - rise_cyc[2], 20);
    chk(rx == 8'h96 && status == 8'h20, "R12", "byte through stretch", rx, 8'h96);
    do_cmd(3'd2, 8'h00, 1'b0, "R4");
    slv_mode = 0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    n_start = 0; n_stop = 0; n_sclfall = 0; bcnt = -1;
    t_reset;
    t_write;
    t_read;
    t_addr_nack;
    t_free_stop;
    t_busy_ignore;
    t_stretch;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_pass, n_pass + n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_pass, n_pass + n_fail);
      $finish;
    end
  end
endmodule